// File: doc/BRIEF.md
# Pipeline Bypass and Squash Controller

This block decides, cycle by cycle, how operands reach the execute stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with eight 16-bit general registers. It compares the decode-stage source register numbers against the destinations of the instructions in execute, memory and writeback. From this it produces bypass selects for the datapath muxes, a stall that freezes fetch and decode, and squash controls that turn pipeline registers into bubbles. The muxes, the ALU, the register file and the memories sit outside.

Only two bypass paths exist. The first passes a writeback result straight into the decode-stage read of the same cycle. The second feeds the result held at the start of the memory stage into the execute operands. The execute-operand select is worked out one cycle early, in decode, against the instruction then in execute, and is registered. Any dependency that neither path can serve stalls decode. This covers a producer two instructions ahead that sits in the memory stage, and a load immediately ahead that sits in execute. Branches are assumed not taken. A branch that resolves taken in execute squashes the two younger instructions. Every register, including register 0 and the link register 7 written by jump-and-link, is tracked the same way.

Top module: `hazard_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, both execute-operand selects read 0.
- R2: A decode read-port bypass output is 1 in the same cycle exactly when that port is read-enabled, the writeback stage writes, and the port's register number equals the writeback destination.
- R3: An execute-operand select is 1 in a cycle exactly when, in the previous cycle, its decode port was read-enabled and matched a writing execute-stage instruction that is not a load, and the previous cycle raised neither a stall nor a squash.
- R4: A read-enabled decode port whose register matches a writing memory-stage destination raises stall_o and flush_ex_o in the same cycle, unless a branch resolves taken.
- R5: A read-enabled decode port whose register matches the destination of a writing load in execute raises stall_o and flush_ex_o in the same cycle, unless a branch resolves taken.
- R6: When br_taken_i is 1, flush_id_o and flush_ex_o are 1 and stall_o is 0. When it is 0, flush_id_o is 0.
- R7: Register numbers 0 and 7 produce bypasses and stalls exactly as any other register does.
- R8: When a decode port matches both the execute-stage writer and the writeback writer, the decode bypass is 1 in that cycle and the execute-operand select is 1 in the next, so the younger result wins. When it matches both the memory-stage writer and the writeback writer, the younger memory-stage producer prevails and the stall is raised.
- R9: A port whose read-enable is 0 raises no bypass, no stall and no execute-operand select, whatever the producers hold.
- R10: With no matching memory-stage writer, no matching load in execute and no taken branch, stall_o and flush_ex_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_src_a_i | input | 3 | Decode read port A register number |
| id_re_a_i | input | 1 | Decode read port A in use |
| id_src_b_i | input | 3 | Decode read port B register number |
| id_re_b_i | input | 1 | Decode read port B in use |
| ex_rd_i | input | 3 | Destination of the instruction in execute |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | 3 | Destination held at the start of memory |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 3 | Destination being written back |
| wb_we_i | input | 1 | Writeback is active |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| id_byp_a_o | output | 1 | Port A takes the writeback value |
| id_byp_b_o | output | 1 | Port B takes the writeback value |
| ex_byp_a_o | output | 1 | Execute operand A takes the memory-stage result |
| ex_byp_b_o | output | 1 | Execute operand B takes the memory-stage result |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| flush_id_o | output | 1 | Turn the fetch-to-decode register into a bubble |
| flush_ex_o | output | 1 | Turn the decode-to-execute register into a bubble |

## Verification
The hardest situation to reach is a registered execute select that has to be cancelled. This happens when the cycle that computed it also stalled or squashed, for instance when port A matches an ALU result in execute while port B matches a memory-stage writer, or while a branch resolves taken. A flat sweep over register numbers and enables for port A reaches these overlaps. Port B, the load flag, writeback and the branch come from a hash of the sweep index. Each cycle's expectation is carried to the next cycle's check. Directed vectors then cover the two-producer priority cases and registers 0 and 7.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  localparam int unsigned NPORT = 2;  // decode read ports
  localparam int unsigned NPROD = 3;  // producer stages
  localparam int unsigned PR_EX  = 0;
  localparam int unsigned PR_MEM = 1;
  localparam int unsigned PR_WB  = 2;
endpackage

// File: rtl/hz_match.sv
`timescale 1ns/1ps
module hz_match #(
  parameter int unsigned RW = 3
) (
  input  logic [RW-1:0] src_i,
  input  logic          re_i,
  input  logic [RW-1:0] dst_i,
  input  logic          we_i,
  output logic          hit_o
);
  // no register is special: r0 and the link register compare like the rest
  assign hit_o = re_i & we_i & (src_i == dst_i);
endmodule

// File: rtl/hz_squash.sv
`timescale 1ns/1ps
module hz_squash (
  input  logic hazard_i,
  input  logic taken_i,
  output logic stall_o,
  output logic flush_id_o,
  output logic flush_ex_o
);
  // a taken branch kills the stalled instruction too, so it wins
  assign stall_o    = hazard_i & ~taken_i;
  assign flush_id_o = taken_i;
  assign flush_ex_o = taken_i | hazard_i;
endmodule

// File: rtl/hz_ex_sel.sv
`timescale 1ns/1ps
module hz_ex_sel #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         kill_i,
  output logic [N-1:0] sel_o
);
  logic [N-1:0] sel_q;

  // select travels with the instruction into execute; a bubble carries none
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (kill_i) sel_q <= '0;
    else             sel_q <= hit_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl #(
  parameter int unsigned NREG = 8,
  localparam int unsigned RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] id_src_a_i,
  input  logic          id_re_a_i,
  input  logic [RW-1:0] id_src_b_i,
  input  logic          id_re_b_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic          br_taken_i,
  output logic          id_byp_a_o,
  output logic          id_byp_b_o,
  output logic          ex_byp_a_o,
  output logic          ex_byp_b_o,
  output logic          stall_o,
  output logic          flush_id_o,
  output logic          flush_ex_o
);
  import hz_pkg::*;

  logic [NPORT-1:0][RW-1:0] src;
  logic [NPORT-1:0]         re;
  logic [NPROD-1:0][RW-1:0] p_rd;
  logic [NPROD-1:0]         p_we;
  logic [NPORT-1:0][NPROD-1:0] hit;
  logic [NPORT-1:0] raw_hz;
  logic [NPORT-1:0] hit_ex;
  logic [NPORT-1:0] hit_wb;
  logic [NPORT-1:0] ex_sel;

  assign src[0] = id_src_a_i;
  assign src[1] = id_src_b_i;
  assign re[0]  = id_re_a_i;
  assign re[1]  = id_re_b_i;

  assign p_rd[PR_EX]  = ex_rd_i;
  assign p_we[PR_EX]  = ex_we_i;
  assign p_rd[PR_MEM] = mem_rd_i;
  assign p_we[PR_MEM] = mem_we_i;
  assign p_rd[PR_WB]  = wb_rd_i;
  assign p_we[PR_WB]  = wb_we_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar k = 0; k < NPROD; k++) begin : g_prod
      hz_match #(.RW(RW)) u_match (
        .src_i (src[p]),
        .re_i  (re[p]),
        .dst_i (p_rd[k]),
        .we_i  (p_we[k]),
        .hit_o (hit[p][k])
      );
    end
    // memory-stage producer has no path to decode; a load in execute has
    // no value yet when this reader reaches execute
    assign raw_hz[p] = hit[p][PR_MEM] | (hit[p][PR_EX] & ex_load_i);
    assign hit_ex[p] = hit[p][PR_EX];
    assign hit_wb[p] = hit[p][PR_WB];
  end

  hz_squash u_squash (
    .hazard_i   (|raw_hz),
    .taken_i    (br_taken_i),
    .stall_o    (stall_o),
    .flush_id_o (flush_id_o),
    .flush_ex_o (flush_ex_o)
  );

  hz_ex_sel #(.N(NPORT)) u_ex_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_ex),
    .kill_i (flush_ex_o),
    .sel_o  (ex_sel)
  );

  assign id_byp_a_o = hit_wb[0];
  assign id_byp_b_o = hit_wb[1];
  assign ex_byp_a_o = ex_sel[0];
  assign ex_byp_b_o = ex_sel[1];
endmodule

// File: rtl/hazard_ctrl_chk.sv
`timescale 1ns/1ps
module hazard_ctrl_chk #(
  parameter int unsigned NREG = 8,
  localparam int unsigned RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [RW-1:0] id_src_a_i,
  input logic          id_re_a_i,
  input logic [RW-1:0] id_src_b_i,
  input logic          id_re_b_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic          wb_we_i,
  input logic          br_taken_i,
  input logic          id_byp_a_o,
  input logic          id_byp_b_o,
  input logic          ex_byp_a_o,
  input logic          ex_byp_b_o,
  input logic          stall_o,
  input logic          flush_id_o,
  input logic          flush_ex_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!ex_byp_a_o && !ex_byp_b_o)); // R1

  AST_WB_BYP_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_byp_a_o || id_byp_b_o) |-> wb_we_i); // R2

  AST_EX_SEL_FROM_ALU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_byp_a_o |-> $past(id_re_a_i && ex_we_i && !ex_load_i && !flush_ex_o)); // R3

  AST_NO_SEL_AFTER_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_ex_o) |-> (!ex_byp_a_o && !ex_byp_b_o)); // R3

  AST_STALL_BUBBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (flush_ex_o && !flush_id_o)); // R4

  AST_SQUASH_BEATS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |-> (!stall_o && flush_id_o && flush_ex_o)); // R6

  AST_STALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (id_re_a_i || id_re_b_i)); // R9

  AST_IDLE_PORT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_re_b_i |-> !id_byp_b_o); // R9

  logic unused_src;
  assign unused_src = ^{id_src_a_i, id_src_b_i};
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.NREG(NREG)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_src_a_i (id_src_a_i),
  .id_re_a_i  (id_re_a_i),
  .id_src_b_i (id_src_b_i),
  .id_re_b_i  (id_re_b_i),
  .ex_we_i    (ex_we_i),
  .ex_load_i  (ex_load_i),
  .wb_we_i    (wb_we_i),
  .br_taken_i (br_taken_i),
  .id_byp_a_o (id_byp_a_o),
  .id_byp_b_o (id_byp_b_o),
  .ex_byp_a_o (ex_byp_a_o),
  .ex_byp_b_o (ex_byp_b_o),
  .stall_o    (stall_o),
  .flush_id_o (flush_id_o),
  .flush_ex_o (flush_ex_o)
);

// File: tb/test_hazard_ctrl.sv
`timescale 1ns/1ps
module test_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] src_a = '0, src_b = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic re_a = 0, re_b = 0, ex_we = 0, ex_ld = 0, mem_we = 0, wb_we = 0, taken = 0;
  logic id_byp_a, id_byp_b, ex_byp_a, ex_byp_b, stall, flush_id, flush_ex;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [1:0] exp_sel = 2'b00;

  always #4 clk = ~clk;  // 125 MHz

  hazard_ctrl i_hazard_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_src_a_i(src_a), .id_re_a_i(re_a), .id_src_b_i(src_b), .id_re_b_i(re_b),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .br_taken_i(taken),
    .id_byp_a_o(id_byp_a), .id_byp_b_o(id_byp_b),
    .ex_byp_a_o(ex_byp_a), .ex_byp_b_o(ex_byp_b),
    .stall_o(stall), .flush_id_o(flush_id), .flush_ex_o(flush_ex)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one pipeline cycle: check last cycle's registered selects, drive, check comb outputs
  task automatic step(input logic [2:0] sa, input logic ra, input logic [2:0] sb, input logic rb,
                      input logic [2:0] er, input logic ew, input logic el,
                      input logic [2:0] mr, input logic mw,
                      input logic [2:0] wr, input logic ww, input logic tk);
    logic [1:0] hx, hm, hw;
    logic hz;
    @(negedge clk);
    chk("R3", ex_byp_a, exp_sel[0]);
    chk("R3", ex_byp_b, exp_sel[1]);
    src_a = sa; re_a = ra; src_b = sb; re_b = rb;
    ex_rd = er; ex_we = ew; ex_ld = el; mem_rd = mr; mem_we = mw;
    wb_rd = wr; wb_we = ww; taken = tk;
    #1;
    hx[0] = ra && ew && (sa == er);  hx[1] = rb && ew && (sb == er);
    hm[0] = ra && mw && (sa == mr);  hm[1] = rb && mw && (sb == mr);
    hw[0] = ra && ww && (sa == wr);  hw[1] = rb && ww && (sb == wr);
    hz = (|hm) || (el && |hx);
    chk("R2", id_byp_a, hw[0]);
    chk("R2", id_byp_b, hw[1]);
    if (tk)        chk("R6", stall, 1'b0);
    else if (|hm)  chk("R4", stall, 1'b1);
    else if (hz)   chk("R5", stall, 1'b1);
    else           chk("R10", stall, 1'b0);
    chk("R6", flush_id, tk);
    chk(tk ? "R6" : "R10", flush_ex, tk || hz);
    exp_sel = (tk || hz) ? 2'b00 : hx;
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: selects held clear during reset despite matching inputs
    src_a = 3'd2; re_a = 1; ex_rd = 3'd2; ex_we = 1;
    src_b = 3'd4; re_b = 1; ex_rd = 3'd2;
    repeat (3) @(negedge clk);
    chk("R1", ex_byp_a, 1'b0);
    chk("R1", ex_byp_b, 1'b0);
    re_a = 0; re_b = 0; ex_we = 0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", ex_byp_a, 1'b0);
    chk("R1", ex_byp_b, 1'b0);

    // R7: register 0 and link register 7
    step(3'd0, 1, 3'd7, 1, 3'd0, 1, 0, 3'd7, 1, 3'd0, 1, 0);
    chk("R7", stall, 1'b1);
    chk("R7", id_byp_a, 1'b1);
    step(3'd7, 1, 3'd0, 1, 3'd7, 1, 0, 3'd3, 0, 3'd0, 1, 0);
    chk("R7", id_byp_b, 1'b1);
    step(3'd1, 0, 3'd1, 0, 3'd1, 0, 0, 3'd1, 0, 3'd1, 0, 0);
    chk("R7", ex_byp_a, 1'b1);

    // R8: younger execute-stage writer beats writeback
    step(3'd5, 1, 3'd2, 0, 3'd5, 1, 0, 3'd1, 0, 3'd5, 1, 0);
    chk("R8", id_byp_a, 1'b1);
    step(3'd0, 0, 3'd0, 0, 3'd0, 0, 0, 3'd0, 0, 3'd0, 0, 0);
    chk("R8", ex_byp_a, 1'b1);
    // R8: memory-stage and writeback both match -> stall
    step(3'd3, 0, 3'd6, 1, 3'd0, 0, 0, 3'd6, 1, 3'd6, 1, 0);
    chk("R8", stall, 1'b1);

    // R9: disabled ports ignore every matching producer
    step(3'd4, 0, 3'd4, 0, 3'd4, 1, 1, 3'd4, 1, 3'd4, 1, 0);
    chk("R9", stall, 1'b0);
    chk("R9", id_byp_a, 1'b0);
    step(3'd4, 0, 3'd4, 0, 3'd4, 1, 0, 3'd0, 0, 3'd0, 0, 0);
    step(3'd0, 0, 3'd0, 0, 3'd0, 0, 0, 3'd0, 0, 3'd0, 0, 0);
    chk("R9", ex_byp_a, 1'b0);
    chk("R9", ex_byp_b, 1'b0);

    // R5 then cancelled select; R6 squash cancels an ALU match
    step(3'd1, 1, 3'd0, 0, 3'd1, 1, 1, 3'd0, 0, 3'd0, 0, 0);
    chk("R5", flush_ex, 1'b1);
    step(3'd2, 1, 3'd0, 0, 3'd2, 1, 0, 3'd0, 0, 3'd0, 0, 1);
    chk("R6", flush_id, 1'b1);

    // sweep: port A exhaustive over numbers and enables, the rest hashed
    for (int v = 0; v < 32768; v++) begin
      logic [31:0] h;
      logic [14:0] u;
      u = v[14:0];
      h = u * 32'h9E3779B1;
      step(u[2:0], u[12], h[23] ? u[5:3] : h[26:24], h[22],
           u[5:3], u[13], h[20], u[8:6], u[14],
           u[11:9], h[21] | h[25], h[31:28] == 4'd0);
    end
    step(3'd0, 0, 3'd0, 0, 3'd0, 0, 0, 3'd0, 0, 3'd0, 0, 0);
    step(3'd0, 0, 3'd0, 0, 3'd0, 0, 0, 3'd0, 0, 3'd0, 0, 0);
    finish_run();
  end
endmodule